// File: doc/BRIEF.md
# Bus transfer size translator

This block sits between a local VMEbus slave port and a multiplexed address/data expansion bus. On each local request it takes the two active-low data strobes, address bit A01 and the active-low long-word qualifier. It packs them into a one-bit size code plus the two low address/data lines of the expansion bus. In a write data phase it moves the written bytes onto the expansion-bus lanes that belong to them. It also drives an odd parity bit. Parity is driven in every address phase this side starts and in write data phases, and never in read data phases.

When read data comes back from the expansion bus, the block steers the addressed bytes onto the local data lanes. It checks the returned parity against the size of the pending cycle. A mismatch raises a one-cycle bus-error request, which the surrounding cycle logic turns into BERR* toward the local master. A qualifier combination that matches none of the seven legal transfer shapes is flagged as illegal, and no expansion-bus cycle is produced for it. Every output is registered, one clock after the request or response that causes it.

Top module: `xfer_size_xlat`

## Requirements
- R1: With `req_ds_n` = {DS1*, DS0*} and `req_lword_n` = 1, the single-byte accesses are coded with size 0 and {ad01, ad00} equal to the byte number. Byte 0 is strobes 01 with A01=0, byte 1 is 10 with A01=0, byte 2 is 01 with A01=1, and byte 3 is 10 with A01=1.
- R2: Both strobes low with `req_lword_n` = 1 is a 16-bit access coded size 1, ad00 0, ad01 equal to A01.
- R3: Both strobes low with A01=0 and `req_lword_n` = 0 is a 32-bit access coded size 1, ad01 1, ad00 1.
- R4: Any other strobe/A01/long-word combination gives `xb_illegal`=1 with `xb_vld`=0, `xb_par_en`=0 and all bus fields zero. It leaves the pending-cycle context unchanged.
- R5: A legal address phase (`req_phase`=0) drives `xb_ad` = {req_addr[31:2], ad01, ad00} with `xb_par_en`=1. `xb_par` makes the count of ones over {xb_par, xb_size, xb_ad} odd.
- R6: A legal write data phase places byte k on `xb_ad` bits [31-8k -: 8], with unused lanes zero, and drives parity as in R5. Local data follows VMEbus lanes: a 32-bit word has byte 0 in bits 31:24. A 16-bit or 8-bit access has its even byte in bits 15:8 and its odd byte in bits 7:0.
- R7: A legal read data phase gives `xb_vld`=1, `xb_ad`=0, `xb_par_en`=0 and `xb_par`=0.
- R8: A response (`rsp_vld`) after a read address phase raises `berr_req` for one cycle when `rsp_par` differs from the odd parity over {size of that cycle, `rsp_ad`}. A response while the last legal address phase was a write, or before any legal address phase, is ignored (`rd_vld`=0, `berr_req`=0).
- R9: For an accepted response, `rd_vld`=1 and `rd_data` holds the addressed bytes on the local lanes of R6, taken from the expansion lanes of R6. All other bits of `rd_data` are zero.
- R10: All outputs are zero after reset and change one clock after the request or response that causes them. Without a request, the bus outputs return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Local request present this cycle |
| req_phase | input | 1 | 0 = address phase, 1 = data phase |
| req_wr | input | 1 | 1 = write cycle |
| req_ds_n | input | 2 | {DS1*, DS0*} data strobes, active low |
| req_a01 | input | 1 | Local address bit 1 |
| req_lword_n | input | 1 | Long-word qualifier, active low |
| req_addr | input | 32 | Local address |
| req_wdata | input | 32 | Local write data on VMEbus lanes |
| rsp_vld | input | 1 | Expansion-bus read data present |
| rsp_ad | input | 32 | Read data from the expansion bus |
| rsp_par | input | 1 | Parity bit received with read data |
| xb_vld | output | 1 | Expansion-bus phase valid |
| xb_phase | output | 1 | Phase of the driven cycle |
| xb_wr | output | 1 | Direction of the driven cycle |
| xb_size | output | 1 | Size code bit |
| xb_ad01 | output | 1 | Low code bit 1 |
| xb_ad00 | output | 1 | Low code bit 0 |
| xb_ad | output | 32 | Address/data driven onto the expansion bus |
| xb_par | output | 1 | Parity bit driven |
| xb_par_en | output | 1 | Parity is driven this phase |
| xb_illegal | output | 1 | Request qualifiers are not a legal shape |
| berr_req | output | 1 | Read parity failure, bus-error request |
| rd_vld | output | 1 | Steered read data valid |
| rd_data | output | 32 | Read data on local VMEbus lanes |

## Verification
A wrong decode entry shows on the next cycle as a wrong size or low-code pair, or as a spurious illegal flag. A wrong lane map shows as bytes in the wrong place on `xb_ad` or `rd_data`. A stale or missing pending-cycle context only shows when a later response arrives. Then the read bytes come from the wrong lanes, or parity is checked against the wrong size and `berr_req` fires or stays silent in error. For that reason the stimulus puts address phases of different sizes between responses, and it drives responses after write cycles as well as after read cycles.

// File: rtl/xsx_pkg.sv
package xsx_pkg;

    localparam int XSX_DW    = 32;
    localparam int XSX_LANES = XSX_DW / 8;

    // Packed transfer-shape code
    typedef struct packed {
        logic legal;
        logic size;
        logic ad01;
        logic ad00;
    } code_t;

    // Registered state of the translator
    typedef struct packed {
        logic              xb_vld;
        logic              xb_phase;
        logic              xb_wr;
        logic              xb_size;
        logic              xb_ad01;
        logic              xb_ad00;
        logic [XSX_DW-1:0] xb_ad;
        logic              xb_par;
        logic              xb_par_en;
        logic              xb_illegal;
        logic              berr;
        logic              rd_vld;
        logic [XSX_DW-1:0] rd_data;
        code_t             ctx;
        logic              ctx_wr;
        logic              ctx_ok;
    } state_t;

    // A 32-bit shape is size=1 with both low code bits set
    function automatic logic is_full(code_t c);
        return c.size & c.ad00;
    endfunction

    // Expansion lanes used by a code; lane l carries byte (LANES-1-l)
    function automatic logic [XSX_LANES-1:0] lane_mask(code_t c);
        logic [XSX_LANES-1:0] m;
        logic [1:0]           li;
        m = '0;
        for (int l = 0; l < XSX_LANES; l++) begin
            li = 2'(l);
            if (is_full(c))
                m[l] = 1'b1;
            else if (c.size)
                m[l] = (li[1] == ~c.ad01);
            else
                m[l] = (li == ~{c.ad01, c.ad00});
        end
        return m & {XSX_LANES{c.legal}};
    endfunction

endpackage

// File: rtl/xsx_decode.sv
module xsx_decode
    import xsx_pkg::*;
(
    input  logic [1:0] ds_n,
    input  logic       a01,
    input  logic       lword_n,
    output code_t      code
);

    always_comb begin
        code = '0;
        unique case ({ds_n, a01, lword_n})
            4'b0101: code = '{legal: 1'b1, size: 1'b0, ad01: 1'b0, ad00: 1'b0};
            4'b1001: code = '{legal: 1'b1, size: 1'b0, ad01: 1'b0, ad00: 1'b1};
            4'b0111: code = '{legal: 1'b1, size: 1'b0, ad01: 1'b1, ad00: 1'b0};
            4'b1011: code = '{legal: 1'b1, size: 1'b0, ad01: 1'b1, ad00: 1'b1};
            4'b0001: code = '{legal: 1'b1, size: 1'b1, ad01: 1'b0, ad00: 1'b0};
            4'b0011: code = '{legal: 1'b1, size: 1'b1, ad01: 1'b1, ad00: 1'b0};
            4'b0000: code = '{legal: 1'b1, size: 1'b1, ad01: 1'b1, ad00: 1'b1};
            default: code = '0;
        endcase
    end

endmodule

// File: rtl/xsx_parity.sv
module xsx_parity #(
    parameter int W = 33
) (
    input  logic [W-1:0] bits,
    output logic         odd_bit
);

    // Bit that makes the total count of ones, itself included, odd
    assign odd_bit = ~(^bits);

endmodule

// File: rtl/xsx_wr_steer.sv
module xsx_wr_steer
    import xsx_pkg::*;
#(
    parameter int DW = XSX_DW
) (
    input  code_t         code,
    input  logic [DW-1:0] local_d,
    output logic [DW-1:0] bus_d
);

    localparam int NL = DW / 8;

    logic [NL-1:0] mask;
    logic          full;

    assign mask = lane_mask(code);
    assign full = is_full(code);

    for (genvar g = 0; g < NL; g++) begin : g_lane
        localparam int SRC = g % 2;
        assign bus_d[8*g +: 8] = !mask[g] ? 8'h00 :
                                 full     ? local_d[8*g +: 8] :
                                            local_d[8*SRC +: 8];
    end

endmodule

// File: rtl/xsx_rd_steer.sv
module xsx_rd_steer
    import xsx_pkg::*;
#(
    parameter int DW = XSX_DW
) (
    input  code_t         code,
    input  logic [DW-1:0] bus_d,
    output logic [DW-1:0] local_d
);

    localparam int NL = DW / 8;

    logic [NL-1:0] mask;
    logic          full;

    assign mask = lane_mask(code);
    assign full = is_full(code);

    always_comb begin
        local_d = '0;
        for (int l = 0; l < NL; l++) begin
            if (mask[l]) begin
                if (full)
                    local_d[8*l +: 8] = bus_d[8*l +: 8];
                else
                    local_d[8*(l%2) +: 8] = local_d[8*(l%2) +: 8] | bus_d[8*l +: 8];
            end
        end
    end

endmodule

// File: rtl/xfer_size_xlat.sv
module xfer_size_xlat
    import xsx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_phase,
    input  logic              req_wr,
    input  logic [1:0]        req_ds_n,
    input  logic              req_a01,
    input  logic              req_lword_n,
    input  logic [XSX_DW-1:0] req_addr,
    input  logic [XSX_DW-1:0] req_wdata,
    input  logic              rsp_vld,
    input  logic [XSX_DW-1:0] rsp_ad,
    input  logic              rsp_par,
    output logic              xb_vld,
    output logic              xb_phase,
    output logic              xb_wr,
    output logic              xb_size,
    output logic              xb_ad01,
    output logic              xb_ad00,
    output logic [XSX_DW-1:0] xb_ad,
    output logic              xb_par,
    output logic              xb_par_en,
    output logic              xb_illegal,
    output logic              berr_req,
    output logic              rd_vld,
    output logic [XSX_DW-1:0] rd_data
);

    localparam int DW = XSX_DW;
    localparam int PW = DW + 1;

    state_t          s_d, s_q;
    code_t           dec;
    logic [DW-1:0]   wr_bus;
    logic [DW-1:0]   rd_local;
    logic [DW-1:0]   tx_ad;
    logic            tx_par;
    logic            rx_par_exp;
    logic            rsp_take;

    xsx_decode u_dec (
        .ds_n    (req_ds_n),
        .a01     (req_a01),
        .lword_n (req_lword_n),
        .code    (dec)
    );

    xsx_wr_steer #(.DW(DW)) u_wst (
        .code    (dec),
        .local_d (req_wdata),
        .bus_d   (wr_bus)
    );

    xsx_rd_steer #(.DW(DW)) u_rst (
        .code    (s_q.ctx),
        .bus_d   (rsp_ad),
        .local_d (rd_local)
    );

    // Value placed on the expansion bus for this request
    always_comb begin
        tx_ad = '0;
        if (dec.legal) begin
            if (!req_phase)
                tx_ad = {req_addr[DW-1:2], dec.ad01, dec.ad00};
            else if (req_wr)
                tx_ad = wr_bus;
        end
    end

    xsx_parity #(.W(PW)) u_tx_par (
        .bits    ({dec.size, tx_ad}),
        .odd_bit (tx_par)
    );

    xsx_parity #(.W(PW)) u_rx_par (
        .bits    ({s_q.ctx.size, rsp_ad}),
        .odd_bit (rx_par_exp)
    );

    assign rsp_take = rsp_vld && s_q.ctx_ok && !s_q.ctx_wr;

    always_comb begin
        s_d            = s_q;
        s_d.xb_vld     = 1'b0;
        s_d.xb_phase   = 1'b0;
        s_d.xb_wr      = 1'b0;
        s_d.xb_size    = 1'b0;
        s_d.xb_ad01    = 1'b0;
        s_d.xb_ad00    = 1'b0;
        s_d.xb_ad      = '0;
        s_d.xb_par     = 1'b0;
        s_d.xb_par_en  = 1'b0;
        s_d.xb_illegal = 1'b0;
        s_d.berr       = 1'b0;
        s_d.rd_vld     = 1'b0;
        s_d.rd_data    = '0;

        if (req_vld) begin
            if (!dec.legal) begin
                s_d.xb_illegal = 1'b1;
            end else begin
                s_d.xb_vld    = 1'b1;
                s_d.xb_phase  = req_phase;
                s_d.xb_wr     = req_wr;
                s_d.xb_size   = dec.size;
                s_d.xb_ad01   = dec.ad01;
                s_d.xb_ad00   = dec.ad00;
                s_d.xb_ad     = tx_ad;
                s_d.xb_par_en = !req_phase || req_wr;
                s_d.xb_par    = (!req_phase || req_wr) ? tx_par : 1'b0;
            end
        end

        // Response is checked against the context held before this cycle
        if (rsp_take) begin
            s_d.rd_vld  = 1'b1;
            s_d.rd_data = rd_local;
            s_d.berr    = (rsp_par != rx_par_exp);
        end

        if (req_vld && dec.legal && !req_phase) begin
            s_d.ctx    = dec;
            s_d.ctx_wr = req_wr;
            s_d.ctx_ok = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign xb_vld     = s_q.xb_vld;
    assign xb_phase   = s_q.xb_phase;
    assign xb_wr      = s_q.xb_wr;
    assign xb_size    = s_q.xb_size;
    assign xb_ad01    = s_q.xb_ad01;
    assign xb_ad00    = s_q.xb_ad00;
    assign xb_ad      = s_q.xb_ad;
    assign xb_par     = s_q.xb_par;
    assign xb_par_en  = s_q.xb_par_en;
    assign xb_illegal = s_q.xb_illegal;
    assign berr_req   = s_q.berr;
    assign rd_vld     = s_q.rd_vld;
    assign rd_data    = s_q.rd_data;

endmodule

// File: rtl/xsx_chk.sv
module xsx_chk
    import xsx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic              rsp_vld,
    input logic              xb_vld,
    input logic              xb_phase,
    input logic              xb_wr,
    input logic              xb_size,
    input logic              xb_ad01,
    input logic              xb_ad00,
    input logic [XSX_DW-1:0] xb_ad,
    input logic              xb_par,
    input logic              xb_par_en,
    input logic              xb_illegal,
    input logic              berr_req,
    input logic              rd_vld
);

    AST_FULL_CODE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (xb_vld && xb_size && xb_ad00) |-> xb_ad01); // R3

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        xb_illegal |-> (!xb_vld && !xb_par_en)); // R4

    AST_ADDR_PAR_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (xb_vld && !xb_phase) |-> xb_par_en); // R5

    AST_PAR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        xb_par_en |-> (^{xb_par, xb_size, xb_ad})); // R5

    AST_WR_DATA_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (xb_vld && xb_phase && xb_wr) |-> xb_par_en); // R6

    AST_RD_DATA_NO_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (xb_vld && xb_phase && !xb_wr) |-> !xb_par_en); // R7

    AST_BERR_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        berr_req |-> ($past(rsp_vld) && rd_vld)); // R8

    AST_OUT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (xb_vld || xb_illegal) |-> $past(req_vld)); // R10

endmodule

bind xfer_size_xlat xsx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .rsp_vld    (rsp_vld),
    .xb_vld     (xb_vld),
    .xb_phase   (xb_phase),
    .xb_wr      (xb_wr),
    .xb_size    (xb_size),
    .xb_ad01    (xb_ad01),
    .xb_ad00    (xb_ad00),
    .xb_ad      (xb_ad),
    .xb_par     (xb_par),
    .xb_par_en  (xb_par_en),
    .xb_illegal (xb_illegal),
    .berr_req   (berr_req),
    .rd_vld     (rd_vld)
);

// File: tb/sim_xfer_size_xlat.sv
module sim_xfer_size_xlat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0, req_phase = 1'b0, req_wr = 1'b0;
    logic [1:0]  req_ds_n = 2'b11;
    logic        req_a01 = 1'b0, req_lword_n = 1'b1;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        rsp_vld = 1'b0;
    logic [31:0] rsp_ad = '0;
    logic        rsp_par = 1'b0;
    logic        xb_vld, xb_phase, xb_wr, xb_size, xb_ad01, xb_ad00;
    logic [31:0] xb_ad;
    logic        xb_par, xb_par_en, xb_illegal, berr_req, rd_vld;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;

    // Bench model of the pending-cycle context
    logic [2:0] m_ctx = '0;   // {size, ad01, ad00}
    logic       m_ctx_wr = 1'b0;
    logic       m_ctx_ok = 1'b0;

    always #5 clk = ~clk;

    xfer_size_xlat u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_phase(req_phase),
        .req_wr(req_wr), .req_ds_n(req_ds_n), .req_a01(req_a01),
        .req_lword_n(req_lword_n), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_vld(rsp_vld), .rsp_ad(rsp_ad), .rsp_par(rsp_par),
        .xb_vld(xb_vld), .xb_phase(xb_phase), .xb_wr(xb_wr), .xb_size(xb_size),
        .xb_ad01(xb_ad01), .xb_ad00(xb_ad00), .xb_ad(xb_ad), .xb_par(xb_par),
        .xb_par_en(xb_par_en), .xb_illegal(xb_illegal), .berr_req(berr_req),
        .rd_vld(rd_vld), .rd_data(rd_data)
    );

    // {legal, size, ad01, ad00} per R1..R4
    function automatic logic [3:0] f_decode(logic [1:0] ds, logic a, logic lw);
        if (lw && ds == 2'b01) return {3'b100, 1'b0} | {2'b00, a, 1'b0};
        if (lw && ds == 2'b10) return {3'b100, 1'b1} | {2'b00, a, 1'b0};
        if (lw && ds == 2'b00) return {2'b11, a, 1'b0};
        if (!lw && ds == 2'b00 && !a) return 4'b1111;
        return 4'b0000;
    endfunction

    function automatic logic [31:0] f_wsteer(logic [2:0] c, logic [31:0] d);
        case (c)
            3'b000: return {d[15:8], 24'h0};
            3'b001: return {8'h0, d[7:0], 16'h0};
            3'b010: return {16'h0, d[15:8], 8'h0};
            3'b011: return {24'h0, d[7:0]};
            3'b100: return {d[15:0], 16'h0};
            3'b110: return {16'h0, d[15:0]};
            3'b111: return d;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] f_rsteer(logic [2:0] c, logic [31:0] b);
        case (c)
            3'b000: return {16'h0, b[31:24], 8'h0};
            3'b001: return {24'h0, b[23:16]};
            3'b010: return {16'h0, b[15:8], 8'h0};
            3'b011: return {24'h0, b[7:0]};
            3'b100: return {16'h0, b[31:16]};
            3'b110: return {16'h0, b[15:0]};
            3'b111: return b;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic f_par(logic s, logic [31:0] v);
        return ~(^{s, v});
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [75:0] act, input logic [75:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic rv, input logic ph, input logic wr,
                        input logic [1:0] ds, input logic a, input logic lw,
                        input logic [31:0] addr, input logic [31:0] wd,
                        input logic sv, input logic [31:0] sad, input logic spar,
                        input string tag);
        logic [3:0]  c;
        logic [40:0] e_bus, a_bus;
        logic [33:0] e_rsp, a_rsp;
        logic [31:0] ead;
        logic        epe, evld, eill;
        @(negedge clk);
        req_vld = rv; req_phase = ph; req_wr = wr; req_ds_n = ds;
        req_a01 = a; req_lword_n = lw; req_addr = addr; req_wdata = wd;
        rsp_vld = sv; rsp_ad = sad; rsp_par = spar;
        c = f_decode(ds, a, lw);
        evld = rv && c[3];
        eill = rv && !c[3];
        ead  = '0;
        epe  = 1'b0;
        if (evld) begin
            if (!ph) begin ead = {addr[31:2], c[1:0]}; epe = 1'b1; end
            else if (wr) begin ead = f_wsteer(c[2:0], wd); epe = 1'b1; end
        end
        e_bus = evld ? {1'b1, ph, wr, c[2:0], ead, epe ? f_par(c[2], ead) : 1'b0, epe, 1'b0}
                     : {40'h0, eill};
        if (sv && m_ctx_ok && !m_ctx_wr)
            e_rsp = {spar != f_par(m_ctx[2], sad), 1'b1, f_rsteer(m_ctx, sad)};
        else
            e_rsp = '0;
        if (evld && !ph) begin m_ctx = c[2:0]; m_ctx_wr = wr; m_ctx_ok = 1'b1; end
        @(posedge clk);
        #2;
        a_bus = {xb_vld, xb_phase, xb_wr, xb_size, xb_ad01, xb_ad00, xb_ad, xb_par, xb_par_en, xb_illegal};
        a_rsp = {berr_req, rd_vld, rd_data};
        chk(a_bus == e_bus, {tag, " bus"}, 76'(a_bus), 76'(e_bus));
        chk(a_rsp == e_rsp, {tag, " rsp"}, 76'(a_rsp), 76'(e_rsp));
    endtask

    function automatic string f_tag(logic [3:0] c);
        if (!c[3]) return "R4";
        if (!c[2]) return "R1/R5";
        if (c[0]) return "R3/R5";
        return "R2/R5";
    endfunction

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        chk({xb_vld, xb_ad, xb_par, xb_par_en, xb_illegal, berr_req, rd_vld, rd_data} == '0,
            "R10 reset", 76'({xb_vld, xb_ad, rd_data}), 76'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // All qualifier combinations in an address phase
        for (int k = 0; k < 16; k++) begin
            logic [3:0] q;
            q = 4'(k);
            step(1'b1, 1'b0, 1'b1, q[3:2], q[1], q[0], 32'hA5C3_0F00 + 32'(k),
                 32'h0, 1'b0, 32'h0, 1'b0, f_tag(f_decode(q[3:2], q[1], q[0])));
        end

        // R6: write data phases of every legal shape
        for (int k = 0; k < 16; k++) begin
            logic [3:0] q;
            q = 4'(k);
            step(1'b1, 1'b1, 1'b1, q[3:2], q[1], q[0], 32'h0, 32'h1122_3344,
                 1'b0, 32'h0, 1'b0, f_decode(q[3:2], q[1], q[0])? "R6" : "R4");
        end

        // R7/R9/R8: read of byte 1, then good and bad parity responses
        step(1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 32'h0000_1000, 32'h0, 1'b0, 32'h0, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 32'h0, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 32'hDEAD_BEEF,
             f_par(1'b0, 32'hDEAD_BEEF), "R9");
        step(1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 32'hDEAD_BEEF,
             ~f_par(1'b0, 32'hDEAD_BEEF), "R8");
        // 16-bit upper-half read: parity uses size 1
        step(1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 32'h0000_2002, 32'h0, 1'b0, 32'h0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 32'h1357_9BDF,
             ~f_par(1'b1, 32'h1357_9BDF), "R8");
        step(1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 32'h1357_9BDF,
             f_par(1'b1, 32'h1357_9BDF), "R9");
        // Illegal address phase keeps the read context
        step(1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 32'h0F0F_F0F0,
             ~f_par(1'b1, 32'h0F0F_F0F0), "R4");
        // Response after a write cycle is ignored
        step(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 32'h0000_3000, 32'h0, 1'b0, 32'h0, 1'b0, "R3");
        step(1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 32'hCAFE_F00D,
             ~f_par(1'b1, 32'hCAFE_F00D), "R8");
        // Idle cycle returns bus to zero
        step(1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, "R10");

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r, ad;
            logic        good;
            r    = $urandom;
            ad   = $urandom;
            good = r[12];
            step(r[1:0] != 2'b00, r[2], r[3], r[5:4], r[6], (r[9:7] == 3'b000) ? 1'b0 : r[10],
                 $urandom, $urandom, r[11] & r[13], ad,
                 good ? f_par(m_ctx[2], ad) : r[14], "RND");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule